// File: doc/BRIEF.md
# Dual-Converter Conversion and Serial Readout Sequencer

This block is the device-side timing core for a pair of 12-bit converters that sample together. A rising edge on the conversion-start input begins a conversion that occupies a fixed number of clock cycles. At the end of that conversion the block latches both converter words, which arrive in parallel from a behavioural stand-in, along with the channel that was sampled. The held words stay put until the next conversion ends, so they can be read any number of times.

A rising edge on the read input starts a serial readout after a short fixed latency. Each frame is 16 bits wide. It holds a channel indicator, a second indicator bit, the 12-bit two's complement result and two trailing zeros, and it is shifted out MSB first. The two mode pins pick one of four behaviours:
- channel chosen by the command register, or alternated automatically;
- both results sent at once on two lines, or sent one after another on line A only.

In single-line operation an extra option sends both frames back to back on a single read request. In that case conversion-start and read can be driven by the same strobe.

Top module: `adcseq_top`

## Requirements
- R1: While reset is asserted and after its release, before any stimulus, `busy`, `conv_done`, `conv_drop`, `sdo_a` and `sdo_b` are 0, and `sdo_b_oe` is 1.
- R2: A rising `conv_start` seen at a clock edge while the block is idle raises `busy` after that edge. `busy` stays high for exactly CONV_CYCLES cycles. `smp_a` and `smp_b` are sampled at the edge where `busy` falls, and `conv_done` is high for the one cycle after that edge.
- R3: A rising `conv_start` seen while a conversion or a readout is in progress is ignored: the running conversion keeps its timing. `conv_drop` is high for the one cycle after that edge.
- R4: The sampled channel is shown on `conv_ch` from the cycle after the start edge.
  - In manual modes (`mode_sel[0]`=0) it is `chan_sel` as sampled at the start edge.
  - In automatic modes (`mode_sel[0]`=1) `chan_sel` is ignored and the channel alternates 0, 1, 0, ... per automatic conversion, beginning with 0 after reset.
- R5: Readout timing:
  - A rising `rd` seen at edge n while no readout is active drives frame bit 15 (the MSB) just after edge n+RD_DELAY (RD_DELAY=2).
  - Each lower bit follows one cycle later.
  - Outside a frame both data lines are 0.
- R6: In dual-line modes (`mode_sel[1]`=0) one read sends {channel, 0, result A, 00} on `sdo_a` and {channel, 0, result B, 00} on `sdo_b` at the same time. Channel sits in bit 15 and the result in bits 13:2.
- R7: In single-line modes (`mode_sel[1]`=1) with `both_read`=0, each read sends one frame {channel, id, result, 00} on `sdo_a`, with id 0 for converter A and 1 for converter B.
  - Successive reads alternate A, B, A, ..., restarting at A after every new result.
  - `sdo_b` stays 0.
- R8: In single-line modes with `both_read`=1, one read sends the A frame immediately followed by the B frame: 32 consecutive bits on `sdo_a`.
- R9: `sdo_b_oe` is 1 from the cycle after any cycle in a dual-line mode. After a switch to a single-line mode it stays 1 until the end of the next conversion, and falls in the cycle after that conversion's last edge.
- R10: Held results change only at the end of a conversion. Repeated reads return the same words even if `smp_a` or `smp_b` change in the meantime.
- R11: A rising `rd` seen while a readout is active is ignored. It neither starts another frame nor advances the A/B alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion and shift clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Conversion start strobe, acts on its rising edge |
| rd | input | 1 | Read strobe, acts on its rising edge |
| mode_sel | input | 2 | Bit 1: single-line output; bit 0: automatic channel alternation |
| chan_sel | input | 1 | Manual channel choice from the command register |
| both_read | input | 1 | Single-line option: both frames per read |
| smp_a | input | 12 | Converter A result from the stand-in |
| smp_b | input | 12 | Converter B result from the stand-in |
| sdo_a | output | 1 | Serial data line A |
| sdo_b | output | 1 | Serial data line B |
| sdo_b_oe | output | 1 | Drive enable for line B (0 means high impedance at the pad) |
| busy | output | 1 | Conversion in progress |
| conv_ch | output | 1 | Channel of the current or latest conversion |
| conv_done | output | 1 | One-cycle pulse after results are latched |
| conv_drop | output | 1 | One-cycle pulse after an ignored start request |

## Verification
The assertions take for granted that every input is synchronous to `clk`. They also assume that `mode_sel` and `both_read` stay still while a frame is being shifted, and that the block never switches from dual-line to single-line mode in the middle of a dual-line frame. In addition, no read request may land on the very edge where a conversion latches its results. The bench changes the mode pins and the option bit only while the block is idle. It places every start and read request on a falling edge at a cycle that it counts explicitly, which keeps read requests clear of the latch edge.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  localparam int unsigned SMP_W = 12;
  localparam int unsigned FRM_W = SMP_W + 4;

  typedef enum logic [1:0] {
    RO_IDLE  = 2'd0,
    RO_WAIT  = 2'd1,
    RO_SHIFT = 2'd2
  } ro_state_e;

  // frame layout: channel flag, second flag, result word, two zero tail bits
  function automatic logic [FRM_W-1:0] make_frame(
    input logic             ch,
    input logic             flag,
    input logic [SMP_W-1:0] word
  );
    return {ch, flag, word, 2'b00};
  endfunction

  function automatic logic mode_single(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_auto(input logic [1:0] m);
    return m[0];
  endfunction

endpackage

// File: rtl/adcseq_conv.sv
module adcseq_conv
  import adcseq_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_in,
  input  logic             rd_busy,
  input  logic             auto_mode,
  input  logic             chan_sel,
  input  logic [SMP_W-1:0] smp_a,
  input  logic [SMP_W-1:0] smp_b,
  output logic             busy,
  output logic             conv_ch,
  output logic             conv_done,
  output logic             conv_drop,
  output logic             start_ev,
  output logic             res_load,
  output logic [SMP_W-1:0] hold_a,
  output logic [SMP_W-1:0] hold_b,
  output logic             hold_ch
);

  localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic             cs_q;
  logic             cs_rise;
  logic             auto_next;
  logic [CNT_W-1:0] cnt;

  assign cs_rise  = cs_in & ~cs_q;
  assign start_ev = cs_rise & ~busy & ~rd_busy;
  assign res_load = busy & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q      <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
      conv_ch   <= 1'b0;
      auto_next <= 1'b0;
      conv_done <= 1'b0;
      conv_drop <= 1'b0;
      hold_a    <= '0;
      hold_b    <= '0;
      hold_ch   <= 1'b0;
    end else begin
      cs_q      <= cs_in;
      conv_done <= res_load;
      conv_drop <= cs_rise & ~start_ev;
      if (start_ev) begin
        busy    <= 1'b1;
        cnt     <= '0;
        conv_ch <= auto_mode ? auto_next : chan_sel;
        if (auto_mode) auto_next <= ~auto_next;
      end else if (busy) begin
        if (res_load) begin
          busy    <= 1'b0;
          hold_a  <= smp_a;
          hold_b  <= smp_b;
          hold_ch <= conv_ch;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/adcseq_rdout.sv
module adcseq_rdout
  import adcseq_pkg::*;
#(
  parameter int unsigned RD_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_in,
  input  logic             single_line,
  input  logic             both_read,
  input  logic [SMP_W-1:0] hold_a,
  input  logic [SMP_W-1:0] hold_b,
  input  logic             hold_ch,
  input  logic             res_load,
  output logic             sdo_a,
  output logic             sdo_b,
  output logic             rd_busy,
  output logic             out_active,
  output logic             rd_take
);

  localparam int unsigned SH_W   = 2 * FRM_W;
  localparam int unsigned BITS_W = $clog2(SH_W + 1);
  localparam int unsigned WCNT_W = $clog2(RD_DELAY + 1);

  ro_state_e         state;
  logic              rd_q;
  logic              dual_q;
  logic              ptr_b;
  logic [SH_W-1:0]   sh_a;
  logic [FRM_W-1:0]  sh_b;
  logic [BITS_W-1:0] left;
  logic [WCNT_W-1:0] wcnt;

  logic [SH_W-1:0]   load_a;
  logic [FRM_W-1:0]  load_b;
  logic [BITS_W-1:0] load_n;
  logic [FRM_W-1:0]  fa_std, fb_std, fb_tag;

  assign rd_take    = rd_in & ~rd_q & (state == RO_IDLE);
  assign rd_busy    = (state != RO_IDLE);
  assign out_active = (state == RO_SHIFT);
  assign sdo_a      = out_active & sh_a[SH_W-1];
  assign sdo_b      = out_active & dual_q & sh_b[FRM_W-1];

  always_comb begin
    fa_std = make_frame(hold_ch, 1'b0, hold_a);
    fb_std = make_frame(hold_ch, 1'b0, hold_b);
    fb_tag = make_frame(hold_ch, 1'b1, hold_b);
    if (!single_line) begin
      load_a = {fa_std, {FRM_W{1'b0}}};
      load_b = fb_std;
      load_n = BITS_W'(FRM_W);
    end else if (both_read) begin
      load_a = {fa_std, fb_tag};
      load_b = '0;
      load_n = BITS_W'(SH_W);
    end else begin
      load_a = {(ptr_b ? fb_tag : fa_std), {FRM_W{1'b0}}};
      load_b = '0;
      load_n = BITS_W'(FRM_W);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RO_IDLE;
      rd_q   <= 1'b0;
      dual_q <= 1'b0;
      ptr_b  <= 1'b0;
      sh_a   <= '0;
      sh_b   <= '0;
      left   <= '0;
      wcnt   <= '0;
    end else begin
      rd_q <= rd_in;
      if (res_load)                                  ptr_b <= 1'b0;
      else if (rd_take && single_line && !both_read) ptr_b <= ~ptr_b;
      case (state)
        RO_IDLE: begin
          if (rd_take) begin
            state  <= RO_WAIT;
            wcnt   <= '0;
            dual_q <= ~single_line;
            sh_a   <= load_a;
            sh_b   <= load_b;
            left   <= load_n;
          end
        end
        RO_WAIT: begin
          if (wcnt == WCNT_W'(RD_DELAY - 1)) state <= RO_SHIFT;
          else                               wcnt  <= wcnt + 1'b1;
        end
        RO_SHIFT: begin
          if (left == BITS_W'(1)) begin
            state <= RO_IDLE;
          end else begin
            sh_a <= {sh_a[SH_W-2:0], 1'b0};
            sh_b <= {sh_b[FRM_W-2:0], 1'b0};
            left <= left - 1'b1;
          end
        end
        default: state <= RO_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adcseq_oe.sv
module adcseq_oe (
  input  logic clk,
  input  logic rst_n,
  input  logic single_line,
  input  logic res_load,
  output logic oe
);

  always_ff @(posedge clk) begin
    if (!rst_n)           oe <= 1'b1;
    else if (!single_line) oe <= 1'b1;
    else if (res_load)     oe <= 1'b0;
  end

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 16,
  parameter int unsigned RD_DELAY    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             rd,
  input  logic [1:0]       mode_sel,
  input  logic             chan_sel,
  input  logic             both_read,
  input  logic [SMP_W-1:0] smp_a,
  input  logic [SMP_W-1:0] smp_b,
  output logic             sdo_a,
  output logic             sdo_b,
  output logic             sdo_b_oe,
  output logic             busy,
  output logic             conv_ch,
  output logic             conv_done,
  output logic             conv_drop
);

  logic             start_ev;
  logic             res_load;
  logic             rd_busy;
  logic             out_active;
  logic             rd_take;
  logic             single_line;
  logic             auto_mode;
  logic [SMP_W-1:0] hold_a;
  logic [SMP_W-1:0] hold_b;
  logic             hold_ch;

  assign single_line = mode_single(mode_sel);
  assign auto_mode   = mode_auto(mode_sel);

  adcseq_conv #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_in     (conv_start),
    .rd_busy   (rd_busy),
    .auto_mode (auto_mode),
    .chan_sel  (chan_sel),
    .smp_a     (smp_a),
    .smp_b     (smp_b),
    .busy      (busy),
    .conv_ch   (conv_ch),
    .conv_done (conv_done),
    .conv_drop (conv_drop),
    .start_ev  (start_ev),
    .res_load  (res_load),
    .hold_a    (hold_a),
    .hold_b    (hold_b),
    .hold_ch   (hold_ch)
  );

  adcseq_rdout #(.RD_DELAY(RD_DELAY)) u_rdout (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_in       (rd),
    .single_line (single_line),
    .both_read   (both_read),
    .hold_a      (hold_a),
    .hold_b      (hold_b),
    .hold_ch     (hold_ch),
    .res_load    (res_load),
    .sdo_a       (sdo_a),
    .sdo_b       (sdo_b),
    .rd_busy     (rd_busy),
    .out_active  (out_active),
    .rd_take     (rd_take)
  );

  adcseq_oe u_oe (
    .clk         (clk),
    .rst_n       (rst_n),
    .single_line (single_line),
    .res_load    (res_load),
    .oe          (sdo_b_oe)
  );

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
  parameter int unsigned CONV_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       chan_sel,
  input logic       busy,
  input logic       conv_ch,
  input logic       conv_done,
  input logic       conv_drop,
  input logic       start_ev,
  input logic       rd_busy,
  input logic       sdo_a,
  input logic       sdo_b,
  input logic       sdo_b_oe
);

  localparam int unsigned BC_W = $clog2(CONV_CYCLES + 2);
  localparam logic [BC_W-1:0] BC_MAX = BC_W'(CONV_CYCLES + 1);

  logic [BC_W-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     bcnt <= '0;
    else if (busy && bcnt != BC_MAX) bcnt <= bcnt + 1'b1;
    else if (!busy)                  bcnt <= '0;
  end

  AST_CONV_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == BC_W'(CONV_CYCLES))); // R2
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < BC_W'(CONV_CYCLES))); // R2
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> $past(busy)); // R2
  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_drop |-> $past(busy || rd_busy)); // R3
  AST_MANUAL_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !mode_sel[0]) |=> (conv_ch == $past(chan_sel))); // R4
  AST_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_busy |-> (!sdo_a && !sdo_b)); // R5
  AST_B_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_b_oe |-> !sdo_b); // R7
  AST_OE_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sel[1] |=> sdo_b_oe); // R9

endmodule

bind adcseq_top adcseq_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_sel  (mode_sel),
  .chan_sel  (chan_sel),
  .busy      (busy),
  .conv_ch   (conv_ch),
  .conv_done (conv_done),
  .conv_drop (conv_drop),
  .start_ev  (start_ev),
  .rd_busy   (rd_busy),
  .sdo_a     (sdo_a),
  .sdo_b     (sdo_b),
  .sdo_b_oe  (sdo_b_oe)
);

// File: tb/adcseq_top_tb.sv
`timescale 1ns/1ps
module adcseq_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0;
  logic        rd = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic        chan_sel = 1'b0;
  logic        both_read = 1'b0;
  logic [11:0] smp_a = '0;
  logic [11:0] smp_b = '0;
  logic        sdo_a, sdo_b, sdo_b_oe, busy, conv_ch, conv_done, conv_drop;

  int checks = 0;
  int fails  = 0;
  logic [31:0] got_a, got_b;

  always #2.5 clk = ~clk;

  adcseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .rd(rd),
    .mode_sel(mode_sel), .chan_sel(chan_sel), .both_read(both_read),
    .smp_a(smp_a), .smp_b(smp_b), .sdo_a(sdo_a), .sdo_b(sdo_b),
    .sdo_b_oe(sdo_b_oe), .busy(busy), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_drop(conv_drop)
  );

  function automatic logic [15:0] exp_frame(input int ch, input int id, input logic [11:0] w);
    return 16'((ch * 32768) + (id * 16384) + (int'(w) * 4));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // conversion from an idle block; checks timing and latched channel
  task automatic do_conv(input logic exp_ch, input string tag);
    conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    chk({tag, " busy after start"}, 32'(busy), 32'd1);
    chk({tag, " conv_ch"}, 32'(conv_ch), 32'(exp_ch));
    repeat (15) @(negedge clk);
    chk({tag, " busy last cycle"}, 32'(busy), 32'd1);
    @(negedge clk);
    chk({tag, " busy low at end"}, 32'(busy), 32'd0);
    chk({tag, " done pulse"}, 32'(conv_done), 32'd1);
  endtask

  // read nbits; inj_at>=0 pulses conv_start (inj_cs) or rd during the frame
  task automatic do_read(input int nbits, input int inj_at, input bit inj_cs, input string tag);
    got_a = '0; got_b = '0;
    rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      got_a = {got_a[30:0], sdo_a};
      got_b = {got_b[30:0], sdo_b};
      if (inj_at >= 0 && inj_cs && i == inj_at + 1)
        chk({tag, " R3 drop during readout"}, 32'(conv_drop), 32'd1);
      if (inj_cs) conv_start = (i == inj_at);
      else        rd = (i == inj_at);
      @(negedge clk);
    end
    conv_start = 1'b0; rd = 1'b0;
    chk({tag, " R5 lines idle after frame"}, {30'd0, sdo_a, sdo_b}, 32'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {26'd0, busy, conv_done, conv_drop, sdo_a, sdo_b, sdo_b_oe}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {26'd0, busy, conv_done, conv_drop, sdo_a, sdo_b, sdo_b_oe}, 32'd1);
  endtask

  task automatic t_manual_dual();
    mode_sel = 2'b00; chan_sel = 1'b1;
    smp_a = 12'h5A3; smp_b = 12'h8F1;
    do_conv(1'b1, "R2 R4 manual");
    do_read(16, -1, 1'b0, "R6 dual");
    chk("R6 dual line A", got_a, 32'(exp_frame(1, 0, 12'h5A3)));
    chk("R6 dual line B", got_b, 32'(exp_frame(1, 0, 12'h8F1)));
  endtask

  task automatic t_hold();
    smp_a = 12'h001; smp_b = 12'hFFF;
    repeat (3) @(negedge clk);
    do_read(16, -1, 1'b0, "R10 reread");
    chk("R10 reread A unchanged", got_a, 32'(exp_frame(1, 0, 12'h5A3)));
    chk("R10 reread B unchanged", got_b, 32'(exp_frame(1, 0, 12'h8F1)));
  endtask

  task automatic t_auto_dual();
    mode_sel = 2'b01; chan_sel = 1'b1;
    smp_a = 12'h7FF; smp_b = 12'h800;
    do_conv(1'b0, "R4 auto first");
    do_read(16, -1, 1'b0, "R6 auto");
    chk("R6 auto line A ch0", got_a, 32'(exp_frame(0, 0, 12'h7FF)));
    chk("R6 auto line B ch0", got_b, 32'(exp_frame(0, 0, 12'h800)));
    smp_a = 12'h123; smp_b = 12'h456;
    do_conv(1'b1, "R4 auto second");
    do_read(16, -1, 1'b0, "R6 auto2");
    chk("R6 auto line A ch1", got_a, 32'(exp_frame(1, 0, 12'h123)));
    chk("R6 auto line B ch1", got_b, 32'(exp_frame(1, 0, 12'h456)));
    do_conv(1'b0, "R4 auto third");
  endtask

  task automatic t_drop();
    mode_sel = 2'b00; chan_sel = 1'b0;
    smp_a = 12'hABC; smp_b = 12'h0F0;
    conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    repeat (5) @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    chk("R3 drop pulse in conversion", 32'(conv_drop), 32'd1);
    chk("R3 still busy", 32'(busy), 32'd1);
    repeat (9) @(negedge clk);
    chk("R3 timing kept busy", 32'(busy), 32'd1);
    @(negedge clk);
    chk("R3 timing kept end", {30'd0, busy, conv_done}, 32'd1);
    do_read(16, 4, 1'b1, "R3 readout");
    chk("R3 no conversion started", 32'(busy), 32'd0);
    chk("R3 readout data", got_a, 32'(exp_frame(0, 0, 12'hABC)));
  endtask

  task automatic t_single();
    mode_sel = 2'b10; chan_sel = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 oe kept before conversion", 32'(sdo_b_oe), 32'd1);
    smp_a = 12'h3C5; smp_b = 12'hC3A;
    do_conv(1'b0, "R7 single");
    chk("R9 oe low after conversion", 32'(sdo_b_oe), 32'd0);
    do_read(16, -1, 1'b0, "R7 first");
    chk("R7 first frame A", got_a, 32'(exp_frame(0, 0, 12'h3C5)));
    chk("R7 line B quiet", got_b, 32'd0);
    do_read(16, -1, 1'b0, "R7 second");
    chk("R7 second frame B", got_a, 32'(exp_frame(0, 1, 12'hC3A)));
    do_read(16, 6, 1'b0, "R11 third");
    chk("R11 third frame A", got_a, 32'(exp_frame(0, 0, 12'h3C5)));
    repeat (20) begin
      chk("R11 no extra frame", {30'd0, sdo_a, sdo_b}, 32'd0);
      @(negedge clk);
    end
    do_read(16, -1, 1'b0, "R11 fourth");
    chk("R11 alternation not advanced", got_a, 32'(exp_frame(0, 1, 12'hC3A)));
  endtask

  task automatic t_both();
    mode_sel = 2'b11; both_read = 1'b1;
    smp_a = 12'h9A5; smp_b = 12'h15E;
    do_conv(1'b1, "R8 both");
    do_read(32, -1, 1'b0, "R8 both");
    chk("R8 back to back frames", got_a, {exp_frame(1, 0, 12'h9A5), exp_frame(1, 1, 12'h15E)});
    chk("R8 line B quiet", got_b, 32'd0);
    both_read = 1'b0;
    mode_sel = 2'b00;
    @(negedge clk);
    chk("R9 oe back in dual mode", 32'(sdo_b_oe), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    t_reset();
    t_manual_dual();
    t_hold();
    t_auto_dual();
    t_drop();
    t_single();
    t_both();
    repeat (3) @(negedge clk);
    summary();
  end

endmodule